// File: doc/BRIEF.md
# Power-Up Delay and Digital Soft-Start Sequencer

This block sequences power-up for a constant-off-time LED current controller. It waits for an undervoltage-lockout flag that already has hysteresis applied. Once that flag goes true, a programmable power-on delay runs, and the gate drive stays disabled for the whole delay. After the delay the block enables the gate and starts a digital ramp. The ramp is the clocked counterpart of a charging soft-start capacitor. It is held at zero through the delay and then climbs by a fixed step every clock.

An external limit code clamps the ramp, in the way a forced soft-start pin voltage would. The peak-current setpoint is the clamped ramp, capped at the full-scale end point and divided by a fixed ratio. A limit below the end point therefore gives analog dimming. A fault request from a neighbouring protection counter latches the block off. Only a supply cycle clears that latch, and the same supply cycle restarts the delay and the ramp.

Top module: `softstart_seq`

## Requirements
- R1: While `rst_n` is low, `gate_en`, `ramp_code`, `peak_code`, `soft_done` and `fault_latched` are all zero.
- R2: After `supply_ok` is first sampled high at a rising edge, `gate_en` stays low for exactly `DELAY_CYC` cycles. From then on it is high while `supply_ok` stays high and no fault is latched.
- R3: `ramp_code` is zero throughout the power-on delay.
- R4: Once the delay has expired, the internal ramp rises by `STEP` on every clock and saturates at `OPEN_MAX`.
- R5: `ramp_code` equals the smaller of the internal ramp and `ext_limit`.
- R6: `peak_code` equals the floor of min(`ramp_code`, `PEAK_MAX`*`RATIO`) divided by `RATIO`, so it never exceeds `PEAK_MAX`.
- R7: `soft_done` is high exactly when the delay has expired and `ramp_code` is at least min(`PEAK_MAX`*`RATIO`, `ext_limit`).
- R8: `fault_trip` sampled high sets `fault_latched` at that edge. The latch holds while `supply_ok` stays high, even after `fault_trip` returns low, and `gate_en` is low while it is set.
- R9: `supply_ok` low drops `gate_en` at once. At the next edge it clears the delay timer, the ramp and the fault latch.
- R10: A supply dip of a single cycle during the delay restarts the full `DELAY_CYC` wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above turn-on threshold (hysteresis applied upstream) |
| ext_limit | input | CODE_W | External ramp clamp code for analog dimming |
| fault_trip | input | 1 | Latch-off request from the fault counter |
| gate_en | output | 1 | Gate drive permitted |
| ramp_code | output | CODE_W | Clamped soft-start ramp value |
| peak_code | output | CODE_W | Peak-current setpoint code |
| soft_done | output | 1 | Ramp has reached its effective end point |
| fault_latched | output | 1 | Latched-off state |

## Verification
The assertions check several invariants on every cycle:
- the delay counter never passes its limit;
- the ramp advances by exactly one step or saturates;
- the gate is off whenever a fault is latched or the delay is running;
- a low supply clears the timer, the ramp and the fault latch;
- the setpoint never exceeds its maximum.

Other behaviours only the bench's scenarios can show. These are the exact length of the delay, the restart after a short dip, the clamp through a changing external limit, and when `soft_done` rises. The bench shows them by comparing every output against a behavioural model on every clock.

// File: rtl/softstart_pkg.sv
package softstart_pkg;
   function automatic int unsigned umin(input int unsigned a, input int unsigned b);
      return (a < b) ? a : b;
   endfunction

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/ss_delay_timer.sv
module ss_delay_timer #(
   parameter int unsigned DELAY_CYC = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   output logic dly_done
);
   localparam int unsigned CW = $clog2(DELAY_CYC + 1);
   localparam logic [CW-1:0] LIMIT = CW'(DELAY_CYC);

   generate
      if (DELAY_CYC < 1) begin : g_bad_delay
         $error("DELAY_CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!supply_ok)     cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
   end

   assign dly_done = (cnt_q == LIMIT);

   p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIMIT);
   p_dip_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> cnt_q == '0);
endmodule

// File: rtl/ss_ramp_gen.sv
module ss_ramp_gen #(
   parameter int unsigned CODE_W   = 10,
   parameter int unsigned STEP     = 4,
   parameter int unsigned OPEN_MAX = 1023
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              supply_ok,
   input  logic              dly_done,
   output logic [CODE_W-1:0] ramp_q
);
   localparam logic [CODE_W-1:0] TOP  = CODE_W'(OPEN_MAX);
   localparam logic [CODE_W-1:0] INC  = CODE_W'(STEP);
   localparam logic [CODE_W-1:0] KNEE = CODE_W'(OPEN_MAX - STEP);

   generate
      if (STEP == 0 || STEP > OPEN_MAX) begin : g_bad_step
         $error("STEP must be in 1..OPEN_MAX");
      end
      if (OPEN_MAX >= (1 << CODE_W)) begin : g_bad_top
         $error("OPEN_MAX must fit in CODE_W bits");
      end
   endgenerate

   logic [CODE_W-1:0] ramp_nx;
   always_comb begin
      if (ramp_q > KNEE) ramp_nx = TOP;
      else               ramp_nx = ramp_q + INC;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       ramp_q <= '0;
      else if (!supply_ok || !dly_done) ramp_q <= '0;
      else                              ramp_q <= ramp_nx;
   end

   p_ramp_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(supply_ok && dly_done) && $past(ramp_q) <= KNEE)
      |-> ramp_q == $past(ramp_q) + INC);
   p_ramp_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ramp_q <= TOP);
   p_ramp_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(dly_done) |-> ramp_q == '0);
endmodule

// File: rtl/ss_fault_latch.sv
module ss_fault_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   input  logic fault_trip,
   output logic latched_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          latched_q <= 1'b0;
      else if (!supply_ok) latched_q <= 1'b0;
      else if (fault_trip) latched_q <= 1'b1;
   end

   p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (latched_q && supply_ok) |=> latched_q);
   p_fault_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> !latched_q);
endmodule

// File: rtl/ss_setpoint.sv
module ss_setpoint #(
   parameter int unsigned CODE_W   = 10,
   parameter int unsigned RATIO    = 3,
   parameter int unsigned PEAK_MAX = 300
) (
   input  logic [CODE_W-1:0] ramp_q,
   input  logic [CODE_W-1:0] ext_limit,
   input  logic              dly_done,
   output logic [CODE_W-1:0] ramp_code,
   output logic [CODE_W-1:0] peak_code,
   output logic              soft_done
);
   import softstart_pkg::*;

   localparam int unsigned END_INT = PEAK_MAX * RATIO;
   localparam logic [CODE_W-1:0] END_CODE = CODE_W'(END_INT);

   generate
      if (RATIO == 0) begin : g_bad_ratio
         $error("RATIO must be nonzero");
      end
      if (END_INT >= (1 << CODE_W)) begin : g_bad_end
         $error("PEAK_MAX*RATIO must fit in CODE_W bits");
      end
   endgenerate

   logic [CODE_W-1:0] capped, target;

   always_comb begin
      ramp_code = (ramp_q < ext_limit) ? ramp_q : ext_limit;
      capped    = (ramp_code < END_CODE) ? ramp_code : END_CODE;
      target    = (ext_limit < END_CODE) ? ext_limit : END_CODE;
      soft_done = dly_done && (ramp_code >= target);
   end

   generate
      if (is_pow2(RATIO)) begin : g_shift_div
         assign peak_code = capped >> $clog2(RATIO);
      end else begin : g_const_div
         assign peak_code = capped / CODE_W'(RATIO);
      end
   endgenerate
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq #(
   parameter int unsigned CODE_W    = 10,
   parameter int unsigned DELAY_CYC = 2000,
   parameter int unsigned STEP      = 4,
   parameter int unsigned OPEN_MAX  = 1023,
   parameter int unsigned RATIO     = 3,
   parameter int unsigned PEAK_MAX  = 300
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              supply_ok,
   input  logic [CODE_W-1:0] ext_limit,
   input  logic              fault_trip,
   output logic              gate_en,
   output logic [CODE_W-1:0] ramp_code,
   output logic [CODE_W-1:0] peak_code,
   output logic              soft_done,
   output logic              fault_latched
);
   generate
      if (PEAK_MAX * RATIO > OPEN_MAX) begin : g_bad_end
         $error("ramp end point exceeds OPEN_MAX");
      end
   endgenerate

   logic              dly_done;
   logic [CODE_W-1:0] ramp_q;

   ss_delay_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .dly_done(dly_done));

   ss_ramp_gen #(.CODE_W(CODE_W), .STEP(STEP), .OPEN_MAX(OPEN_MAX)) u_ramp (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .dly_done(dly_done),
      .ramp_q(ramp_q));

   ss_fault_latch u_fault (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .fault_trip(fault_trip),
      .latched_q(fault_latched));

   ss_setpoint #(.CODE_W(CODE_W), .RATIO(RATIO), .PEAK_MAX(PEAK_MAX)) u_set (
      .ramp_q(ramp_q), .ext_limit(ext_limit), .dly_done(dly_done),
      .ramp_code(ramp_code), .peak_code(peak_code), .soft_done(soft_done));

   assign gate_en = dly_done && supply_ok && !fault_latched;

   p_gate_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
      gate_en |-> ramp_code == '0 || $past(gate_en) || $past(dly_done));
   p_gate_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fault_latched |-> !gate_en);
   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> ramp_code == '0 && !fault_latched);
   p_peak_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      peak_code <= CODE_W'(PEAK_MAX));
   p_done_after_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
      soft_done |-> !$past(!supply_ok) || ramp_code == '0);
endmodule

// File: tb/softstart_seq_bench.sv
module softstart_seq_bench;
   localparam int PERIOD = 10;
   localparam int W = 10, D = 200, STEP = 4, OMAX = 1023, RATIO = 3, PMAX = 300;
   localparam int ENDC = PMAX * RATIO;

   logic clk = 1'b0, rst_n = 1'b0, supply_ok = 1'b0, fault_trip = 1'b0;
   logic [W-1:0] ext_limit = W'(OMAX);
   logic gate_en, soft_done, fault_latched;
   logic [W-1:0] ramp_code, peak_code;

   int checks = 0, failures = 0;
   int m_hi = 0, m_ramp = 0, m_flt = 0;
   bit started = 0, finished = 0;

   always #(PERIOD/2) clk = ~clk;

   softstart_seq #(.CODE_W(W), .DELAY_CYC(D), .STEP(STEP), .OPEN_MAX(OMAX),
                   .RATIO(RATIO), .PEAK_MAX(PMAX)) u_softstart_seq (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ext_limit(ext_limit),
      .fault_trip(fault_trip), .gate_en(gate_en), .ramp_code(ramp_code),
      .peak_code(peak_code), .soft_done(soft_done), .fault_latched(fault_latched));

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s at %0t: got %0d expected %0d", tag, $time, got, exp);
      end
   endtask

   // behavioural reference, advanced once per rising edge
   always @(posedge clk) begin
      started = 1;
      if (!rst_n) begin
         m_hi = 0; m_ramp = 0; m_flt = 0;
      end else begin
         bit was_done;
         was_done = (m_hi == D);
         if (!supply_ok) begin
            m_hi = 0; m_ramp = 0; m_flt = 0;
         end else begin
            if (m_hi < D) m_hi++;
            m_ramp = was_done ? ((m_ramp + STEP > OMAX) ? OMAX : m_ramp + STEP) : 0;
            if (fault_trip) m_flt = 1;
         end
      end
   end

   always @(negedge clk) begin
      if (started && rst_n && !finished) begin
         int eff, cap, tgt, dd;
         dd  = (m_hi == D);
         eff = (m_ramp < int'(ext_limit)) ? m_ramp : int'(ext_limit);
         cap = (eff < ENDC) ? eff : ENDC;
         tgt = (int'(ext_limit) < ENDC) ? int'(ext_limit) : ENDC;
         chk("R2 R8 R9 R10 gate_en", int'(gate_en), int'(dd && supply_ok && !m_flt));
         chk("R3 R4 R5 R9 ramp_code", int'(ramp_code), eff);
         chk("R6 peak_code", int'(peak_code), cap / RATIO);
         chk("R7 soft_done", int'(soft_done), int'(dd && eff >= tgt));
         chk("R8 R9 fault_latched", int'(fault_latched), m_flt);
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      #(PERIOD * 60000);
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      step(3);
      // R1: reset state
      chk("R1 gate_en", int'(gate_en), 0);
      chk("R1 ramp_code", int'(ramp_code), 0);
      chk("R1 peak_code", int'(peak_code), 0);
      chk("R1 soft_done", int'(soft_done), 0);
      chk("R1 fault_latched", int'(fault_latched), 0);
      rst_n = 1'b1;
      step(5);
      supply_ok = 1'b1;
      step(D - 1);
      chk("R2 gate still low", int'(gate_en), 0);
      step(1);
      chk("R2 gate high after delay", int'(gate_en), 1);
      step(300);                      // ramp saturates, R4
      chk("R4 saturated ramp", int'(ramp_code), OMAX);
      ext_limit = W'(500);            // analog dimming clamp, R5
      step(20);
      chk("R6 dimmed peak", int'(peak_code), 500 / RATIO);
      ext_limit = W'(0);
      step(10);
      ext_limit = W'(OMAX);
      fault_trip = 1'b1;
      step(1);
      fault_trip = 1'b0;
      step(20);
      chk("R8 latch holds", int'(fault_latched), 1);
      supply_ok = 1'b0;               // R9 supply cycle
      step(1);
      supply_ok = 1'b1;
      step(D / 2);
      supply_ok = 1'b0;               // R10 dip mid-delay
      step(1);
      supply_ok = 1'b1;
      step(D - 1);
      chk("R10 full delay again", int'(gate_en), 0);
      step(1);
      chk("R10 gate after restart", int'(gate_en), 1);
      ext_limit = W'(300);
      step(150);
      step(2);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule